// File: doc/BRIEF.md
# Potentiometer register file with non-volatile shadow

This block keeps the register state behind a digitally controlled potentiometer. A bus front end hands it single-byte read and write requests on a 5-bit register address. It answers reads from a combinational mux and routes writes either to a live wiper register, to a bank of non-volatile bytes, or to a small control register. One address is shared by the live wiper and its non-volatile power-on value. A control bit decides which of the two that address reaches. The outputs are the wiper code and a shutdown flag for the resistor switch matrix.

Non-volatile writes are staged when they are requested. They are programmed by a self-timed cycle that the front end starts with a pulse when the bus transaction ends. The cycle lasts a parameter number of clocks, during which a busy flag is raised. The storage cells are flops that only the reset input clears; the supply-good input models power cycling. While the supply is not good, the wiper sits at midscale and the block ignores all writes. When the supply becomes good, the stored power-on value is recalled into the wiper, and only then does the block signal that the front end may leave standby.

Top module: `dpot_regfile`

## Requirements
- R1: With the control register's bit 7 (volatile select) at 1, a write to address 00h changes only the live wiper, and a read of 00h returns the live wiper. After bit 7 returns to 0, a read of 00h shows the stored power-on value unchanged.
- R2: With bit 7 at 0, a write to address 00h is staged as a non-volatile write to the power-on value and copies the byte into the live wiper on the next clock. After the programming cycle, a read of 00h returns the new byte.
- R3: Addresses 01h to 0Eh hold general-purpose non-volatile bytes that read back what was programmed. Writes to 0Fh and to addresses above 10h have no effect, and reads of these addresses return 00h.
- R4: The control register sits at address 10h. Bit 7 is the volatile select and bit 6 is the enable, and both are writable. Bit 5 is the read-only busy flag, and bits 4..0 read as 0. After reset, bit 7 is 0 and bit 6 is 1. `pot_shutdown` is the inverse of bit 6.
- R5: While a programming cycle runs, writes to the live wiper and writes to the control register are refused.
- R6: A non-volatile write is held pending, with `nv_busy` low, until a `txn_stop` pulse arrives. `nv_busy` then stays high for exactly NV_WRITE_CYCLES clocks, and the byte is readable once it falls. Control bit 5 mirrors `nv_busy`.
- R7: A non-volatile write request that arrives while another one is pending or programming is dropped, and `nv_err` pulses for one clock.
- R8: While `supply_ok` is low, the wiper is 80h, `bus_ready` is low, the control register returns to its reset value, any pending or running programming cycle is abandoned, and writes have no effect.
- R9: After `supply_ok` rises, one recall clock loads the stored power-on value into the wiper, and then `bus_ready` goes high.
- R10: Asserting `rst_n` sets every non-volatile byte to NV_RESET_VAL and the wiper to 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Supply valid; low forces power-down behaviour |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write data |
| txn_stop | input | 1 | Pulse at the end of a write transaction; starts programming |
| rd_data | output | 8 | Read data for req_addr (combinational) |
| bus_ready | output | 1 | Recall finished; front end may leave standby |
| wiper_code | output | 8 | Wiper tap code, 00h nearest low end |
| pot_shutdown | output | 1 | Potentiometer in shutdown |
| nv_busy | output | 1 | Non-volatile programming in progress |
| nv_err | output | 1 | One-clock pulse on a dropped non-volatile write |

## Verification
The bench builds the block with NV_WRITE_CYCLES set to 12, so the busy window can be counted clock by clock. At that length, refused wiper and control writes, and a colliding non-volatile request, all fit inside one running cycle. NV_RESET_VAL is 33h, which makes reset contents and recalled values distinct from midscale and from zero. GP_COUNT stays at 14, so both reserved addresses, 0Fh and 11h, can be reached.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] WIPER_ADDR = 5'h00;
  localparam logic [REG_ADDR_W-1:0] CTRL_ADDR  = 5'h10;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    PWR_OFF    = 2'd0,
    PWR_RECALL = 2'd1,
    PWR_ON     = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/dpot_power_seq.sv
module dpot_power_seq
  import dpot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic recall_en,
  output logic live
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_OFF:    if (supply_ok) state_d = PWR_RECALL;
      PWR_RECALL: state_d = PWR_ON;
      PWR_ON:     state_d = PWR_ON;
      default:    state_d = PWR_OFF;
    endcase
    if (!supply_ok) state_d = PWR_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  assign recall_en = (state_q == PWR_RECALL) && supply_ok;
  assign live      = (state_q == PWR_ON);

  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_en && supply_ok) |=> live);  // R9

endmodule

// File: rtl/dpot_nv_store.sv
module dpot_nv_store
  import dpot_pkg::*;
#(
  parameter int    SLOTS        = 15,
  parameter int    WRITE_CYCLES = 2500000,
  parameter byte_t RESET_VAL    = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  abort,
  input  logic                  stage_req,
  input  logic [REG_ADDR_W-1:0] stage_slot,
  input  byte_t                 stage_data,
  input  logic                  commit_go,
  input  logic [REG_ADDR_W-1:0] rd_slot,
  output byte_t                 rd_data,
  output byte_t                 ivr,
  output logic                  stage_ok,
  output logic                  busy,
  output logic                  reject
);

  localparam int              CNT_W    = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic                  pend_q, pend_d;
  logic                  busy_q, busy_d;
  logic                  rej_q, rej_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [REG_ADDR_W-1:0] slot_q, slot_d;
  byte_t                 data_q, data_d;
  logic                  done;
  logic [SLOTS-1:0][BYTE_W-1:0] cells;

  assign stage_ok = !pend_q && !busy_q;
  assign done     = busy_q && (cnt_q == '0);

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    data_d = data_q;
    rej_d  = stage_req && !stage_ok;
    if (stage_req && stage_ok) begin
      pend_d = 1'b1;
      slot_d = stage_slot;
      data_d = stage_data;
    end
    if (commit_go && pend_q && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (abort) begin
      pend_d = 1'b0;
      busy_d = 1'b0;
      cnt_d  = '0;
      rej_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      rej_q  <= 1'b0;
      cnt_q  <= '0;
      slot_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      rej_q  <= rej_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      data_q <= data_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_cell
    byte_t cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= RESET_VAL;
      else if (done && !abort && (slot_q == REG_ADDR_W'(s))) cell_q <= data_q;
    end
    assign cells[s] = cell_q;
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_slot == REG_ADDR_W'(s)) rd_data = cells[s];
    end
  end

  assign ivr    = cells[0];
  assign busy   = busy_q;
  assign reject = rej_q;

  AST_CYCLE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> pend_q);  // R6

  AST_INFLIGHT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !abort) |=> ($stable(slot_q) && $stable(data_q)));  // R7

endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int          NV_WRITE_CYCLES = 2500000,
  parameter int          GP_COUNT        = 14,
  parameter logic [7:0]  NV_RESET_VAL    = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [4:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       txn_stop,
  output logic [7:0] rd_data,
  output logic       bus_ready,
  output logic [7:0] wiper_code,
  output logic       pot_shutdown,
  output logic       nv_busy,
  output logic       nv_err
);

  localparam int    SLOTS    = GP_COUNT + 1;
  localparam byte_t MIDSCALE = byte_t'(1 << (BYTE_W - 1));

  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic  live, recall_en;
  logic  wr_go, hit_wiper, hit_ctrl, hit_gp;
  logic  nv_req, wiper_wr, ctrl_wr;
  logic  stage_ok, busy_w, reject_w;
  byte_t nv_rd, ivr_byte;
  byte_t wiper_q, wiper_d;
  logic  vol_q, vol_d, shdn_q, shdn_d;

  dpot_power_seq i_pwr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .supply_ok (supply_ok),
    .recall_en (recall_en),
    .live      (live)
  );

  assign hit_wiper = (req_addr == WIPER_ADDR);
  assign hit_ctrl  = (req_addr == CTRL_ADDR);
  assign hit_gp    = !hit_wiper && (req_addr <= REG_ADDR_W'(GP_COUNT));
  assign wr_go     = req_valid && req_write && live;
  assign nv_req    = wr_go && ((hit_wiper && !vol_q) || hit_gp);
  assign wiper_wr  = wr_go && hit_wiper && (vol_q ? !busy_w : stage_ok);
  assign ctrl_wr   = wr_go && hit_ctrl && !busy_w;

  dpot_nv_store #(
    .SLOTS        (SLOTS),
    .WRITE_CYCLES (NV_WRITE_CYCLES),
    .RESET_VAL    (NV_RESET_VAL)
  ) i_nv (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .abort      (!supply_ok),
    .stage_req  (nv_req),
    .stage_slot (req_addr),
    .stage_data (req_wdata),
    .commit_go  (txn_stop && live),
    .rd_slot    (req_addr),
    .rd_data    (nv_rd),
    .ivr        (ivr_byte),
    .stage_ok   (stage_ok),
    .busy       (busy_w),
    .reject     (reject_w)
  );

  always_comb begin
    wiper_d = wiper_q;
    vol_d   = vol_q;
    shdn_d  = shdn_q;
    if (!supply_ok) begin
      wiper_d = MIDSCALE;
      vol_d   = 1'b0;
      shdn_d  = 1'b1;
    end else begin
      if (recall_en)     wiper_d = ivr_byte;
      else if (wiper_wr) wiper_d = req_wdata;
      if (ctrl_wr) begin
        vol_d  = req_wdata[7];
        shdn_d = req_wdata[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      wiper_q <= MIDSCALE;
      vol_q   <= 1'b0;
      shdn_q  <= 1'b1;
    end else begin
      wiper_q <= wiper_d;
      vol_q   <= vol_d;
      shdn_q  <= shdn_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_wiper)   rd_data = vol_q ? wiper_q : ivr_byte;
    else if (hit_gp) rd_data = nv_rd;
    else if (hit_ctrl) rd_data = {vol_q, shdn_q, busy_w, 5'b00000};
  end

  assign bus_ready    = live;
  assign wiper_code   = wiper_q;
  assign pot_shutdown = !shdn_q;
  assign nv_busy      = busy_w;
  assign nv_err       = reject_w;

  AST_DOWN_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !supply_ok |=> ((wiper_code == MIDSCALE) && !bus_ready));  // R8

  AST_RECALL_LOADS_IVR: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(bus_ready) |-> (wiper_code == ivr_byte));  // R9

  AST_BUSY_HOLDS_WIPER: assert property (@(posedge clk) disable iff (!rst_n_int)
    (nv_busy && bus_ready && supply_ok) |=> $stable(wiper_code));  // R5

  AST_BUSY_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n_int)
    (nv_busy && bus_ready && supply_ok) |=> ($stable(vol_q) && $stable(shdn_q)));  // R5

endmodule

// File: tb/test_dpot_regfile.sv
module test_dpot_regfile;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       req_valid, req_write, txn_stop;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;
  logic [7:0] rd_data, wiper_code;
  logic       bus_ready, pot_shutdown, nv_busy, nv_err;

  int applied = 0;
  int miscompares = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dpot_regfile #(
    .NV_WRITE_CYCLES (12),
    .GP_COUNT        (14),
    .NV_RESET_VAL    (8'h33)
  ) i_dpot_regfile (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .txn_stop     (txn_stop),
    .rd_data      (rd_data),
    .bus_ready    (bus_ready),
    .wiper_code   (wiper_code),
    .pot_shutdown (pot_shutdown),
    .nv_busy      (nv_busy),
    .nv_err       (nv_err)
  );

  // op(4) addr(8) data(8) req(4): 1 write, 2 read, 3 stop+wait, 4 wiper, 5 shutdown
  localparam int NVEC = 30;
  localparam logic [23:0] VECS [NVEC] = '{
    24'h2_10_40_4,  // R4 reset control value
    24'h1_01_A5_3,  // R3
    24'h3_00_00_6,  // R6
    24'h2_01_A5_3,  // R3
    24'h1_0E_5C_3,  // R3
    24'h3_00_00_6,  // R6
    24'h2_0E_5C_3,  // R3
    24'h2_01_A5_3,  // R3
    24'h1_0F_77_3,  // R3 reserved
    24'h2_0F_00_3,  // R3
    24'h1_11_77_3,  // R3 out of map
    24'h2_11_00_3,  // R3
    24'h2_05_33_A,  // R10 reset content
    24'h1_00_C8_2,  // R2
    24'h4_00_C8_2,  // R2 wiper copy
    24'h3_00_00_6,  // R6
    24'h2_00_C8_2,  // R2
    24'h1_10_80_4,  // R4
    24'h2_10_80_4,  // R4
    24'h5_00_01_4,  // R4 shutdown
    24'h1_00_11_1,  // R1
    24'h4_00_11_1,  // R1
    24'h2_00_11_1,  // R1
    24'h1_10_40_4,  // R4
    24'h2_00_C8_1,  // R1 stored value untouched
    24'h4_00_11_1,  // R1
    24'h5_00_00_4,  // R4
    24'h1_10_FF_4,  // R4
    24'h2_10_C0_4,  // R4 bit 5 and low bits
    24'h1_10_40_4   // R4
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    req_valid = 1'b0; req_addr = a;
    #1;
    check(req, "read", rd_data, exp);
  endtask

  task automatic stop_pulse();
    @(negedge clk);
    txn_stop = 1'b1;
    @(negedge clk);
    txn_stop = 1'b0;
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; txn_stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset and power-down state
    check("R10", "wiper after reset", wiper_code, 8'h80);
    check("R8", "ready while down", {7'd0, bus_ready}, 8'h00);
    check("R4", "shutdown after reset", {7'd0, pot_shutdown}, 8'h00);
    check("R6", "busy after reset", {7'd0, nv_busy}, 8'h00);
    wr(5'h10, 8'h80);
    rd("R8", 5'h10, 8'h40);

    // power-up recall
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk);
    check("R9", "ready in recall cycle", {7'd0, bus_ready}, 8'h00);
    @(negedge clk);
    check("R9", "ready after recall", {7'd0, bus_ready}, 8'h01);
    check("R9", "recalled wiper", wiper_code, 8'h33);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i][3:0]);
      case (VECS[i][23:20])
        4'd1: wr(VECS[i][16:12], VECS[i][11:4]);
        4'd2: rd(tag, VECS[i][16:12], VECS[i][11:4]);
        4'd3: begin stop_pulse(); wait_idle(); end
        4'd4: begin @(negedge clk); check(tag, "wiper", wiper_code, VECS[i][11:4]); end
        4'd5: begin @(negedge clk); check(tag, "shutdown", {7'd0, pot_shutdown}, VECS[i][11:4]); end
        default: ;
      endcase
    end

    // R6: pending, then busy for exactly the cycle length
    wr(5'h02, 8'h3C);
    check("R6", "busy while only pending", {7'd0, nv_busy}, 8'h00);
    check("R7", "no error on accepted write", {7'd0, nv_err}, 8'h00);
    stop_pulse();
    begin
      int n;
      n = 0;
      while (nv_busy) begin n++; @(negedge clk); end
      check("R6", "busy length", n[7:0], 8'd12);
    end
    rd("R6", 5'h02, 8'h3C);

    // R5 / R7 inside a running cycle
    wr(5'h10, 8'hC0);
    wr(5'h06, 8'h3C);
    stop_pulse();
    rd("R6", 5'h10, 8'hE0);
    wr(5'h00, 8'h99);
    check("R5", "wiper write refused", wiper_code, 8'h11);
    wr(5'h10, 8'h40);
    rd("R5", 5'h10, 8'hE0);
    wr(5'h03, 8'h99);
    check("R7", "error on busy write", {7'd0, nv_err}, 8'h01);
    @(negedge clk);
    check("R7", "error is one pulse", {7'd0, nv_err}, 8'h00);
    wait_idle();
    rd("R6", 5'h06, 8'h3C);
    rd("R7", 5'h03, 8'h33);

    // R7: collision with a pending (not yet started) write
    wr(5'h10, 8'h40);
    wr(5'h04, 8'h11);
    wr(5'h05, 8'h22);
    check("R7", "error on pending collision", {7'd0, nv_err}, 8'h01);
    stop_pulse(); wait_idle();
    rd("R7", 5'h04, 8'h11);
    rd("R7", 5'h05, 8'h33);

    // R8 / R9: power loss during a cycle
    wr(5'h10, 8'h80);
    check("R4", "shutdown set", {7'd0, pot_shutdown}, 8'h01);
    wr(5'h07, 8'h66);
    stop_pulse();
    supply_ok = 1'b0;
    @(negedge clk);
    check("R8", "wiper midscale when down", wiper_code, 8'h80);
    check("R8", "ready low when down", {7'd0, bus_ready}, 8'h00);
    check("R8", "cycle abandoned", {7'd0, nv_busy}, 8'h00);
    check("R8", "control defaults", {7'd0, pot_shutdown}, 8'h00);
    wr(5'h10, 8'h80);
    rd("R8", 5'h10, 8'h40);
    check("R8", "wiper unchanged when down", wiper_code, 8'h80);
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9", "ready after power cycle", {7'd0, bus_ready}, 8'h01);
    check("R9", "wiper recalled after power cycle", wiper_code, 8'hC8);
    rd("R8", 5'h07, 8'h33);

    // R10: reset restores stored bytes
    @(negedge clk); rst_n = 1'b0;
    #1;
    rd("R10", 5'h01, 8'h33);
    check("R10", "wiper in reset", wiper_code, 8'h80);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10", "recall after reset", wiper_code, 8'h33);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule